// File: doc/BRIEF.md
# UART Transmit Framer with Parity Control

This block turns one data word into an asynchronous serial frame on a single output line. A frame is a low start bit, then 5 to 8 data bits sent least significant bit first, then an optional parity bit, then one or two high stop bits. Each bit lasts a fixed number of baud ticks, 16 by default. A strobe marks each tick, and a divider outside the block produces it.

A small control register sets the frame shape. It holds the word length, the stop count, parity enable, parity select, stick parity and a break control. The break control is active low: while it is 0 the line is held low. The sequencer keeps counting underneath, so the frame still ends on time.

A word is accepted with a one-cycle load strobe while the block is not busy. The frame-shaping fields are captured at that moment. The break control stays live for the whole frame.

Top module: `sertx_framer`

## Requirements
- R1: After reset the control register reads 0x0000, busy is low, and txd is low, because the break control resets to 0.
- R2: The control register layout is: bits [1:0] word length code (data bits = 5 + code), bit 2 stop count (0 = one, 1 = two), bit 3 parity enable, bit 4 parity select, bit 5 stick parity, bit 6 break control. A write takes effect on the next cycle. Bits [15:7] always read as zero.
- R3: With break control at 1 and no frame in progress, txd is high. A load strobe while idle raises busy on the next cycle and starts a low start bit lasting 16 ticks.
- R4: Data bits follow the start bit least significant bit first. The count is 5 + word length code, and bits above that count are not sent.
- R5: With parity enable at 0, no parity bit is sent, whatever the parity select and stick parity bits hold.
- R6: With parity enabled and stick parity at 0, parity select 0 sends odd parity and parity select 1 sends even parity over the sent data bits.
- R7: With parity enabled and stick parity at 1, the parity bit is the inverse of parity select: 0 when select is 1, 1 when select is 0.
- R8: The frame ends with one or two high stop bits, as the stop count sets. Busy falls exactly 16 × (frame bit count) ticks after the load.
- R9: Writing 0 to the break control forces txd low from the next cycle. The frame keeps advancing underneath. Writing 1 restores the normal line, and the frame ends at its usual time.
- R10: While baud_tick is low, a frame in progress makes no progress: txd and busy hold.
- R11: A load strobe while busy is ignored. The current frame is unchanged and no further frame follows it.
- R12: Writes to the frame-shaping fields during a frame do not change that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle oversampling tick strobe |
| load_valid | input | 1 | Load strobe for a new word |
| load_data | input | 8 | Word to send |
| ctl_wr | input | 1 | Control register write enable |
| ctl_wdata | input | 16 | Control register write data |
| ctl_rdata | output | 16 | Control register contents, reserved bits zero |
| txd | output | 1 | Serial line |
| busy | output | 1 | High while a frame is in progress |

## Verification
The bench samples every bit of the frame at its midpoint and checks when busy falls, at one-tick resolution. A design with a length off by one, a wrong stop count, or a parity bit sent while parity is disabled therefore shows a shifted or extra bit, or busy falling at the wrong tick. Parity data are chosen so that odd and even parity differ, and stick parity differs from normal parity, which exposes a swapped select polarity or stick values taken from the parity tree.

The bench drops the break control in the middle of a frame. A design that froze the sequencer during break, or that treated the bit as active-high, would show the line at the wrong level or end the frame late. Other stimuli cover a tick gap, a load strobe while busy, and a control rewrite during a frame. These catch designs that advance without ticks, start a stray second frame, or reshape a frame already in flight.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  localparam int unsigned CTL_W     = 16;
  localparam int unsigned LIVE_W    = 7;
  localparam int unsigned WL_W      = 2;
  localparam int unsigned WLEN_LSB  = 0;
  localparam int unsigned STOP2_BIT = 2;
  localparam int unsigned PEN_BIT   = 3;
  localparam int unsigned PSEL_BIT  = 4;
  localparam int unsigned STICK_BIT = 5;
  localparam int unsigned BRK_BIT   = 6;

  typedef struct packed {
    logic [WL_W-1:0] wlen;
    logic            two_stop;
    logic            par_en;
    logic            par_sel;
    logic            par_stick;
  } frame_cfg_t;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } tx_state_e;

  function automatic frame_cfg_t decode_cfg(input logic [LIVE_W-1:0] f);
    frame_cfg_t c;
    c.wlen      = f[WLEN_LSB +: WL_W];
    c.two_stop  = f[STOP2_BIT];
    c.par_en    = f[PEN_BIT];
    c.par_sel   = f[PSEL_BIT];
    c.par_stick = f[STICK_BIT];
    return c;
  endfunction

endpackage

// File: rtl/sertx_ctlreg.sv
module sertx_ctlreg
  import sertx_pkg::*;
#(
  parameter int unsigned RD_W = CTL_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [LIVE_W-1:0]   wdata,
  output logic [RD_W-1:0]     rdata,
  output frame_cfg_t          cfg,
  output logic                brk_n
);

  localparam int unsigned PAD_W = RD_W - LIVE_W;

  logic [LIVE_W-1:0] live_q;
  logic [LIVE_W-1:0] live_d;

  always_comb begin
    live_d = live_q;
    if (wr_en) begin
      live_d = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= '0;
    end else begin
      live_q <= live_d;
    end
  end

  assign rdata = {{PAD_W{1'b0}}, live_q};
  assign cfg   = decode_cfg(live_q);
  assign brk_n = live_q[BRK_BIT];

endmodule

// File: rtl/sertx_parity.sv
module sertx_parity
  import sertx_pkg::*;
#(
  parameter int unsigned DW       = 8,
  parameter int unsigned MIN_BITS = 5
) (
  input  logic [DW-1:0]   data,
  input  logic [WL_W-1:0] wlen,
  input  logic            par_sel,
  input  logic            par_stick,
  output logic            par_bit
);

  localparam int unsigned NB_W = $clog2(DW + 1);

  logic [NB_W-1:0] nbits;
  logic [DW-1:0]   keep;
  logic            ones_odd;

  assign nbits = NB_W'(MIN_BITS) + NB_W'(wlen);

  for (genvar i = 0; i < DW; i++) begin : g_mask
    assign keep[i] = (NB_W'(i) < nbits);
  end

  assign ones_odd = ^(data & keep);

  always_comb begin
    if (par_stick) begin
      par_bit = ~par_sel;
    end else if (par_sel) begin
      par_bit = ones_odd;
    end else begin
      par_bit = ~ones_odd;
    end
  end

endmodule

// File: rtl/sertx_seq.sv
module sertx_seq
  import sertx_pkg::*;
#(
  parameter int unsigned DW       = 8,
  parameter int unsigned MIN_BITS = 5,
  parameter int unsigned OVS      = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            baud_tick,
  input  logic            load_valid,
  input  logic [DW-1:0]   load_data,
  input  logic [WL_W-1:0] wlen,
  input  logic            two_stop,
  input  logic            par_en,
  input  logic            par_in,
  output logic            line_bit,
  output logic            busy
);

  localparam int unsigned TICK_W = (OVS > 1) ? $clog2(OVS) : 1;
  localparam int unsigned CNT_W  = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(OVS - 1);

  tx_state_e       state_q, state_d;
  logic [TICK_W-1:0] tick_q, tick_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DW-1:0]     sh_q, sh_d;
  logic [WL_W-1:0]   wlen_q, wlen_d;
  logic              stop2_q, stop2_d;
  logic              pen_q, pen_d;
  logic              par_q, par_d;
  logic              bit_end;
  logic [CNT_W-1:0]  last_idx;

  assign bit_end  = baud_tick && (tick_q == TICK_LAST);
  assign last_idx = CNT_W'(MIN_BITS - 1) + CNT_W'(wlen_q);

  always_comb begin
    state_d = state_q;
    tick_d  = tick_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    wlen_d  = wlen_q;
    stop2_d = stop2_q;
    pen_d   = pen_q;
    par_d   = par_q;

    if (state_q != ST_IDLE && baud_tick) begin
      tick_d = bit_end ? '0 : tick_q + 1'b1;
    end

    unique case (state_q)
      ST_IDLE: begin
        if (load_valid) begin
          state_d = ST_START;
          tick_d  = '0;
          cnt_d   = '0;
          sh_d    = load_data;
          wlen_d  = wlen;
          stop2_d = two_stop;
          pen_d   = par_en;
          par_d   = par_in;
        end
      end
      ST_START: begin
        if (bit_end) begin
          state_d = ST_DATA;
          cnt_d   = '0;
        end
      end
      ST_DATA: begin
        if (bit_end) begin
          sh_d = sh_q >> 1;
          if (cnt_q == last_idx) begin
            cnt_d   = '0;
            state_d = pen_q ? ST_PAR : ST_STOP;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_PAR: begin
        if (bit_end) begin
          state_d = ST_STOP;
          cnt_d   = '0;
        end
      end
      ST_STOP: begin
        if (bit_end) begin
          if (stop2_q && (cnt_q == '0)) begin
            cnt_d = CNT_W'(1);
          end else begin
            state_d = ST_IDLE;
            cnt_d   = '0;
          end
        end
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tick_q  <= '0;
      cnt_q   <= '0;
      sh_q    <= '0;
      wlen_q  <= '0;
      stop2_q <= 1'b0;
      pen_q   <= 1'b0;
      par_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      tick_q  <= tick_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      wlen_q  <= wlen_d;
      stop2_q <= stop2_d;
      pen_q   <= pen_d;
      par_q   <= par_d;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_START: line_bit = 1'b0;
      ST_DATA:  line_bit = sh_q[0];
      ST_PAR:   line_bit = par_q;
      default:  line_bit = 1'b1;
    endcase
  end

  assign busy = (state_q != ST_IDLE);

endmodule

// File: rtl/sertx_framer.sv
module sertx_framer
  import sertx_pkg::*;
#(
  parameter int unsigned DW       = 8,
  parameter int unsigned MIN_BITS = 5,
  parameter int unsigned OVS      = 16,
  parameter int unsigned REG_W    = CTL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             baud_tick,
  input  logic             load_valid,
  input  logic [DW-1:0]    load_data,
  input  logic             ctl_wr,
  input  logic [REG_W-1:0] ctl_wdata,
  output logic [REG_W-1:0] ctl_rdata,
  output logic             txd,
  output logic             busy
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  frame_cfg_t cfg;
  logic       brk_n;
  logic       par_bit;
  logic       line_bit;
  logic       unused_rsvd_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  assign unused_rsvd_wdata = ^ctl_wdata[REG_W-1:LIVE_W];

  sertx_ctlreg #(
    .RD_W (REG_W)
  ) u_ctl (
    .clk   (clk),
    .rst_n (rst_int_n),
    .wr_en (ctl_wr),
    .wdata (ctl_wdata[LIVE_W-1:0]),
    .rdata (ctl_rdata),
    .cfg   (cfg),
    .brk_n (brk_n)
  );

  sertx_parity #(
    .DW       (DW),
    .MIN_BITS (MIN_BITS)
  ) u_par (
    .data      (load_data),
    .wlen      (cfg.wlen),
    .par_sel   (cfg.par_sel),
    .par_stick (cfg.par_stick),
    .par_bit   (par_bit)
  );

  sertx_seq #(
    .DW       (DW),
    .MIN_BITS (MIN_BITS),
    .OVS      (OVS)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .baud_tick  (baud_tick),
    .load_valid (load_valid),
    .load_data  (load_data),
    .wlen       (cfg.wlen),
    .two_stop   (cfg.two_stop),
    .par_en     (cfg.par_en),
    .par_in     (par_bit),
    .line_bit   (line_bit),
    .busy       (busy)
  );

  assign txd = brk_n & line_bit;

endmodule

// File: rtl/sertx_checker.sv
module sertx_checker #(
  parameter int unsigned REG_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             baud_tick,
  input logic             load_valid,
  input logic             ctl_wr,
  input logic [REG_W-1:0] ctl_wdata,
  input logic [REG_W-1:0] ctl_rdata,
  input logic             txd,
  input logic             busy
);

  assert_ctl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (ctl_rdata[6:0] == $past(ctl_wdata[6:0])));

  assert_idle_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata[6] && !busy) |-> txd);

  assert_load_starts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && load_valid) |=> busy);

  assert_start_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd);

  assert_break_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_rdata[6] |-> !txd);

  assert_no_tick_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !baud_tick && !ctl_wr) |=> (busy && $stable(txd)));

endmodule

bind sertx_framer sertx_checker #(.REG_W(REG_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .baud_tick  (baud_tick),
  .load_valid (load_valid),
  .ctl_wr     (ctl_wr),
  .ctl_wdata  (ctl_wdata),
  .ctl_rdata  (ctl_rdata),
  .txd        (txd),
  .busy       (busy)
);

// File: tb/sim_sertx_framer.sv
`timescale 1ns/1ps
module sim_sertx_framer;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        baud_tick;
  logic        load_valid;
  logic [7:0]  load_data;
  logic        ctl_wr;
  logic [15:0] ctl_wdata;
  logic [15:0] ctl_rdata;
  logic        txd;
  logic        busy;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sertx_framer u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .baud_tick  (baud_tick),
    .load_valid (load_valid),
    .load_data  (load_data),
    .ctl_wr     (ctl_wr),
    .ctl_wdata  (ctl_wdata),
    .ctl_rdata  (ctl_rdata),
    .txd        (txd),
    .busy       (busy)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Expected frame built from the requirements: start, data LSB first, parity, stops
  function automatic int build(input logic [7:0] d, input logic [15:0] c,
                               output logic [15:0] b);
    int n;
    int wl;
    logic x;
    b  = '1;
    n  = 0;
    wl = 5 + int'(c[1:0]);
    b[n] = 1'b0; n++;
    x = 1'b0;
    for (int i = 0; i < wl; i++) begin
      b[n] = d[i]; n++;
      x = x ^ d[i];
    end
    if (c[3]) begin
      if (c[5]) b[n] = ~c[4];
      else      b[n] = c[4] ? x : ~x;
      n++;
    end
    b[n] = 1'b1; n++;
    if (c[2]) begin
      b[n] = 1'b1; n++;
    end
    return n;
  endfunction

  task automatic wr_ctl(input logic [15:0] v);
    @(negedge clk);
    ctl_wr    = 1'b1;
    ctl_wdata = v;
    @(negedge clk);
    ctl_wr    = 1'b0;
  endtask

  // kind: 0 plain, 1 load while busy, 2 control rewrite, 3 break pulse, 4 tick gap
  task automatic run_frame(input logic [7:0] d, input logic [15:0] c,
                           input int kind, input string req);
    logic [15:0] b;
    int n;
    logic e;
    wr_ctl(c);
    n = build(d, c, b);
    chk(txd === 1'b1, "R3", "idle line", 32'(txd), 32'd1);
    @(negedge clk);
    load_data  = d;
    load_valid = 1'b1;
    @(negedge clk);
    load_valid = 1'b0;
    chk(busy === 1'b1 && txd === 1'b0, "R3", "start after load",
        {busy, txd}, 32'b10);
    for (int k = 1; k <= 16 * n; k++) begin
      @(negedge clk);
      if (k % 16 == 8) begin
        e = b[k / 16];
        if (kind == 3 && k >= 25 && k <= 56) e = 1'b0;
        chk(txd === e, req, $sformatf("bit %0d", k / 16), 32'(txd), 32'(e));
      end
      if (k == 16 * n - 1)
        chk(busy === 1'b1, "R8", "busy before last tick", 32'(busy), 32'd1);
      if (k == 16 * n)
        chk(busy === 1'b0 && txd === 1'b1, "R8", "frame end", {busy, txd}, 32'b01);
      if (kind == 1) begin
        if (k == 40) begin load_valid = 1'b1; load_data = ~d; end
        else if (k == 41) load_valid = 1'b0;
      end
      if (kind == 2) begin
        if (k == 20) begin ctl_wr = 1'b1; ctl_wdata = 16'h007B; end
        else if (k == 21) ctl_wr = 1'b0;
      end
      if (kind == 3) begin
        if (k == 24) begin ctl_wr = 1'b1; ctl_wdata = c & ~16'h0040; end
        else if (k == 25) begin
          ctl_wr = 1'b0;
          chk(txd === 1'b0, "R9", "break takes effect", 32'(txd), 32'd0);
        end
        else if (k == 56) begin ctl_wr = 1'b1; ctl_wdata = c; end
        else if (k == 57) ctl_wr = 1'b0;
      end
      if (kind == 4 && k == 30) begin
        logic t0;
        int bad;
        t0 = txd;
        bad = 0;
        baud_tick = 1'b0;
        repeat (20) begin
          @(negedge clk);
          if (txd !== t0 || busy !== 1'b1) bad++;
        end
        chk(bad == 0, "R10", "hold without ticks", 32'(bad), 32'd0);
        baud_tick = 1'b1;
      end
    end
    if (kind == 1) begin
      int bad;
      bad = 0;
      repeat (40) begin
        @(negedge clk);
        if (busy !== 1'b0 || txd !== 1'b1) bad++;
      end
      chk(bad == 0, "R11", "no frame after ignored load", 32'(bad), 32'd0);
    end
  endtask

  task automatic t_reset;
    chk(ctl_rdata === 16'h0000, "R1", "control after reset", ctl_rdata, 32'h0);
    chk(busy === 1'b0, "R1", "busy after reset", 32'(busy), 32'd0);
    chk(txd === 1'b0, "R1", "txd after reset", 32'(txd), 32'd0);
  endtask

  task automatic t_ctlreg;
    wr_ctl(16'hFFFF);
    chk(ctl_rdata === 16'h007F, "R2", "reserved bits zero", ctl_rdata, 32'h7F);
    wr_ctl(16'hAA55);
    chk(ctl_rdata === 16'h0055, "R2", "readback", ctl_rdata, 32'h55);
  endtask

  initial begin
    rst_n      = 1'b0;
    baud_tick  = 1'b1;
    load_valid = 1'b0;
    load_data  = '0;
    ctl_wr     = 1'b0;
    ctl_wdata  = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_ctlreg();
    run_frame(8'hA5, 16'h0043, 0, "R4");  // 8 bits, no parity, one stop
    run_frame(8'h13, 16'h004C, 0, "R6");  // 5 bits, odd parity, two stops (R8)
    run_frame(8'h5B, 16'h005A, 0, "R6");  // 7 bits, even parity
    run_frame(8'h01, 16'h007B, 0, "R7");  // stick, select 1 -> parity 0
    run_frame(8'h07, 16'h006B, 0, "R7");  // stick, select 0 -> parity 1
    run_frame(8'h2C, 16'h0071, 0, "R5");  // parity off with select and stick set
    run_frame(8'h3C, 16'h0043, 3, "R9");
    run_frame(8'h96, 16'h0043, 4, "R10");
    run_frame(8'h5A, 16'h0043, 1, "R11");
    run_frame(8'hC6, 16'h004C, 2, "R12");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog R3 actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule